// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers root-port interrupt events into two first-stage status registers and folds whatever is pending and unmasked there into a single summary bit. That summary bit lives in a host-level status register, and the host level drives one level-sensitive interrupt line. Event inputs may be one-cycle pulses or held levels. They cover:

- the four legacy lines, with separate assert and deassert events;
- an MSI-pending event;
- a power-management message;
- a power-state change;
- a flush event.

Software uses a simple register port to read the status registers, to clear bits by writing ones to them, and to program the mask registers. In every mask register, a 1 blocks the bit.

A legacy assert event is recorded at both levels. An interrupt handler can therefore service the lines from either register.

Top module: `intr_status_aggr`

## Requirements
- R1: After synchronous reset, all three status registers read 0 and `irq` is 0. The mask registers read as follows: first-level mask 0x06FFFFFF (all bits masked except MSI-pending bit 24), second-level mask 0x00000FF0, host mask 0x00FEF0FB (only summary bit 16 unmasked).
- R2: First-level bit positions are fixed. MSI-pending sets bit 24 and the power-management message sets bit 7. Legacy line n assert sets bit 16+n and legacy line n deassert sets bit 20+n, for n = 0..3. A bit is set on the clock edge that samples its event and reads 1 from the following cycle.
- R3: Second-level bit positions are fixed. Power-state change sets bit 4, flush sets bit 5, and legacy line n assert sets bit 8+n.
- R4: Writing to a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: When an event and a write-one-to-clear of the same status bit occur in the same cycle, the bit stays set.
- R6: A status bit whose mask bit is 1 is still recorded in its status register but does not contribute to the summary.
- R7: Host status bit 16 becomes set one edge after any first- or second-level bit is pending and unmasked. If it is cleared while such a bit is still pending, it is set again.
- R8: `irq` is 1 exactly when a host status bit is set and its host mask bit is 0. Setting host mask bit 16 forces `irq` low while host status still reads bit 16 set.
- R9: Only the valid fields are stored; bits outside them read 0 in both status and mask registers. The valid fields are: first level bits 26:0, second level bits 11:4, host level mask 0x00FFF0FB.
- R10: Address map: 0 first-level status, 1 first-level mask, 2 second-level status, 3 second-level mask, 4 host status, 5 host mask. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_assert | input | 4 | Legacy line assert events, one per line |
| intx_deassert | input | 4 | Legacy line deassert events, one per line |
| msi_evt | input | 1 | MSI pending event |
| pme_evt | input | 1 | Power-management message event |
| pwr_chg_evt | input | 1 | Power-state change event |
| flush_evt | input | 1 | Flush event |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level-sensitive interrupt output |

## Verification
Each fault shows up at the ports on a predictable cycle:

- A status bit placed at the wrong position, or lost, shows up on the read port one cycle after its event.
- A wrong summary decision shows up on `irq` two edges after the event: one edge to record the event, one edge to set the summary.
- A reset mask value that is wrong shows up the moment the masks are read back after reset. It also shows up as `irq` rising, or failing to rise, for the events that mask should block.
- A clear that wrongly overrides a simultaneous event, or a summary that fails to re-arm, shows up as a zero read on the very next cycle.

// File: rtl/intr_aggr_pkg.sv
package intr_aggr_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int NUM_INTX = 4;

    // first level layout
    localparam int L1_ASSERT_BASE   = 16;
    localparam int L1_DEASSERT_BASE = 20;
    localparam int L1_MSI_BIT       = 24;
    localparam int L1_PME_BIT       = 7;
    localparam logic [REG_W-1:0] L1_VALID = 32'h07FF_FFFF;

    // second level layout
    localparam int L2_PWR_BIT         = 4;
    localparam int L2_FLUSH_BIT       = 5;
    localparam int L2_ASSERT_BASE     = 8;
    localparam logic [REG_W-1:0] L2_VALID = 32'h0000_0FF0;

    // host level layout
    localparam int HOST_CORE_BIT = 16;
    localparam logic [REG_W-1:0] HOST_VALID = 32'h00FF_F0FB;

    // reset masks: only the listed bits start unmasked
    localparam logic [REG_W-1:0] L1_MASK_RST   = L1_VALID & ~(REG_W'(1) << L1_MSI_BIT);
    localparam logic [REG_W-1:0] L2_MASK_RST   = L2_VALID;
    localparam logic [REG_W-1:0] HOST_MASK_RST = HOST_VALID & ~(REG_W'(1) << HOST_CORE_BIT);

    typedef enum logic [ADDR_W-1:0] {
        A_L1_STAT   = 3'd0,
        A_L1_MASK   = 3'd1,
        A_L2_STAT   = 3'd2,
        A_L2_MASK   = 3'd3,
        A_HOST_STAT = 3'd4,
        A_HOST_MASK = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_INTX-1:0] assert_ev;
        logic [NUM_INTX-1:0] deassert_ev;
        logic                msi;
        logic                pme;
        logic                pwr;
        logic                flush;
    } evt_bundle_t;

    function automatic logic [REG_W-1:0] summary_set(input logic any_pending);
        logic [REG_W-1:0] v;
        v = '0;
        v[HOST_CORE_BIT] = any_pending;
        return v;
    endfunction

endpackage

// File: rtl/intr_evt_map.sv
module intr_evt_map
    import intr_aggr_pkg::*;
(
    input  evt_bundle_t      evt,
    output logic [REG_W-1:0] l1_set,
    output logic [REG_W-1:0] l2_set
);

    always_comb begin
        l1_set = '0;
        l2_set = '0;
        for (int n = 0; n < NUM_INTX; n++) begin
            l1_set[L1_ASSERT_BASE + n]   = evt.assert_ev[n];
            l1_set[L1_DEASSERT_BASE + n] = evt.deassert_ev[n];
            l2_set[L2_ASSERT_BASE + n]   = evt.assert_ev[n];
        end
        l1_set[L1_MSI_BIT]   = evt.msi;
        l1_set[L1_PME_BIT]   = evt.pme;
        l2_set[L2_PWR_BIT]   = evt.pwr;
        l2_set[L2_FLUSH_BIT] = evt.flush;
    end

endmodule

// File: rtl/intr_stat_bank.sv
module intr_stat_bank #(
    parameter int             W        = 32,
    parameter logic [W-1:0]   VALID    = '1,
    parameter logic [W-1:0]   MASK_RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         stat_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         any_pend
);

    logic [W-1:0] clr_vec;
    logic [W-1:0] status_nxt;

    always_comb begin
        clr_vec    = stat_wr ? wdata : '0;
        // a set in the same cycle overrides a clear
        status_nxt = ((status & ~clr_vec) | set_vec) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= MASK_RST & VALID;
        end else begin
            status <= status_nxt;
            if (mask_wr) mask <= wdata & VALID;
        end
    end

    assign any_pend = |(status & ~mask & VALID);

endmodule

// File: rtl/intr_status_aggr.sv
module intr_status_aggr
    import intr_aggr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_INTX-1:0] intx_assert,
    input  logic [NUM_INTX-1:0] intx_deassert,
    input  logic                msi_evt,
    input  logic                pme_evt,
    input  logic                pwr_chg_evt,
    input  logic                flush_evt,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    output logic                irq
);

    evt_bundle_t      evt;
    logic [REG_W-1:0] l1_set, l2_set, host_set;
    logic [REG_W-1:0] l1_stat, l1_mask, l2_stat, l2_mask, host_stat, host_mask;
    logic             l1_any, l2_any, host_any;

    assign evt = '{assert_ev:   intx_assert,
                   deassert_ev: intx_deassert,
                   msi:         msi_evt,
                   pme:         pme_evt,
                   pwr:         pwr_chg_evt,
                   flush:       flush_evt};

    intr_evt_map u_map (
        .evt    (evt),
        .l1_set (l1_set),
        .l2_set (l2_set)
    );

    intr_stat_bank #(.W(REG_W), .VALID(L1_VALID), .MASK_RST(L1_MASK_RST)) u_l1 (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (l1_set),
        .stat_wr  (wr_en && addr == A_L1_STAT),
        .mask_wr  (wr_en && addr == A_L1_MASK),
        .wdata    (wdata),
        .status   (l1_stat),
        .mask     (l1_mask),
        .any_pend (l1_any)
    );

    intr_stat_bank #(.W(REG_W), .VALID(L2_VALID), .MASK_RST(L2_MASK_RST)) u_l2 (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (l2_set),
        .stat_wr  (wr_en && addr == A_L2_STAT),
        .mask_wr  (wr_en && addr == A_L2_MASK),
        .wdata    (wdata),
        .status   (l2_stat),
        .mask     (l2_mask),
        .any_pend (l2_any)
    );

    assign host_set = summary_set(l1_any | l2_any);

    intr_stat_bank #(.W(REG_W), .VALID(HOST_VALID), .MASK_RST(HOST_MASK_RST)) u_host (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (host_set),
        .stat_wr  (wr_en && addr == A_HOST_STAT),
        .mask_wr  (wr_en && addr == A_HOST_MASK),
        .wdata    (wdata),
        .status   (host_stat),
        .mask     (host_mask),
        .any_pend (host_any)
    );

    assign irq = host_any;

    always_comb begin
        case (addr)
            A_L1_STAT:   rdata = l1_stat;
            A_L1_MASK:   rdata = l1_mask;
            A_L2_STAT:   rdata = l2_stat;
            A_L2_MASK:   rdata = l2_mask;
            A_HOST_STAT: rdata = host_stat;
            A_HOST_MASK: rdata = host_mask;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/intr_status_aggr_chk.sv
module intr_status_aggr_chk
    import intr_aggr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             msi_evt,
    input logic             pme_evt,
    input logic             flush_evt,
    input logic             irq,
    input logic             l1_any,
    input logic             l2_any,
    input logic [REG_W-1:0] l1_stat,
    input logic [REG_W-1:0] l2_stat,
    input logic [REG_W-1:0] host_stat,
    input logic [REG_W-1:0] host_mask
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (host_stat == '0 && l1_stat == '0 && !irq));

    // R2
    msi_latch_chk: assert property (@(posedge clk) disable iff (rst)
        msi_evt |=> l1_stat[L1_MSI_BIT]);

    // R2
    pme_latch_chk: assert property (@(posedge clk) disable iff (rst)
        pme_evt |=> l1_stat[L1_PME_BIT]);

    // R3
    flush_latch_chk: assert property (@(posedge clk) disable iff (rst)
        flush_evt |=> l2_stat[L2_FLUSH_BIT]);

    // R7
    summary_set_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_any || l2_any) |=> host_stat[HOST_CORE_BIT]);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (host_stat[HOST_CORE_BIT] && !host_mask[HOST_CORE_BIT]));

    // R9
    valid_field_chk: assert property (@(posedge clk) disable iff (rst)
        ((l1_stat & ~L1_VALID) == '0) && ((l2_stat & ~L2_VALID) == '0)
        && ((host_stat & ~HOST_VALID) == '0));

endmodule

bind intr_status_aggr intr_status_aggr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msi_evt   (msi_evt),
    .pme_evt   (pme_evt),
    .flush_evt (flush_evt),
    .irq       (irq),
    .l1_any    (l1_any),
    .l2_any    (l2_any),
    .l1_stat   (l1_stat),
    .l2_stat   (l2_stat),
    .host_stat (host_stat),
    .host_mask (host_mask)
);

// File: tb/sim_intr_status_aggr.sv
module sim_intr_status_aggr;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  intx_assert = '0;
    logic [3:0]  intx_deassert = '0;
    logic        msi_evt = 1'b0;
    logic        pme_evt = 1'b0;
    logic        pwr_chg_evt = 1'b0;
    logic        flush_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_status_aggr u0 (
        .clk, .rst, .intx_assert, .intx_deassert, .msi_evt, .pme_evt,
        .pwr_chg_evt, .flush_evt, .wr_en, .addr, .wdata, .rdata, .irq
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [3:0]  d;
        logic        msi;
        logic        pme;
        logic        pwr;
        logic        fl;
        logic        irq;
        logic [31:0] l1;
        logic [31:0] l2;
    } vec_t;

    // expected values derived from the bit positions in R2/R3 and reset masks in R1
    localparam vec_t VECS [NVEC] = '{
        '{4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0100},
        '{4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0008_0000, 32'h0000_0800},
        '{4'b0000, 4'b0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0050_0000, 32'h0000_0000},
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0100_0000, 32'h0000_0000},
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0080, 32'h0000_0010},
        '{4'b0000, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0080_0000, 32'h0000_0020},
        '{4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h01FF_0080, 32'h0000_0F30}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic clear_all();
        do_write(3'd0, 32'hFFFF_FFFF);
        do_write(3'd2, 32'hFFFF_FFFF);
        do_write(3'd4, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 l1 stat", 3'd0, 32'h0);
        rd_check("R1 l1 mask", 3'd1, 32'h06FF_FFFF);
        rd_check("R1 l2 stat", 3'd2, 32'h0);
        rd_check("R1 l2 mask", 3'd3, 32'h0000_0FF0);
        rd_check("R1 host stat", 3'd4, 32'h0);
        rd_check("R1 host mask", 3'd5, 32'h00FE_F0FB);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R10 unmapped addresses
        rd_check("R10 addr6", 3'd6, 32'h0);
        rd_check("R10 addr7", 3'd7, 32'h0);

        // vector table: R2, R3, R6 (masked events do not raise irq)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            intx_assert = VECS[i].a; intx_deassert = VECS[i].d;
            msi_evt = VECS[i].msi; pme_evt = VECS[i].pme;
            pwr_chg_evt = VECS[i].pwr; flush_evt = VECS[i].fl;
            @(negedge clk);
            intx_assert = '0; intx_deassert = '0;
            msi_evt = 0; pme_evt = 0; pwr_chg_evt = 0; flush_evt = 0;
            @(negedge clk);
            rd_check("R2 l1 vector", 3'd0, VECS[i].l1);
            rd_check("R3 l2 vector", 3'd2, VECS[i].l2);
            check("R6 irq vector", {31'h0, irq}, {31'h0, VECS[i].irq});
            clear_all();
            rd_check("R4 host cleared", 3'd4, 32'h0);
        end

        // R9 only valid bits are stored
        do_write(3'd1, 32'hFFFF_FFFF);
        rd_check("R9 l1 mask field", 3'd1, 32'h07FF_FFFF);
        do_write(3'd3, 32'hFFFF_FFFF);
        rd_check("R9 l2 mask field", 3'd3, 32'h0000_0FF0);
        do_write(3'd5, 32'hFFFF_FFFF);
        rd_check("R9 host mask field", 3'd5, 32'h00FF_F0FB);
        do_write(3'd1, 32'h06FF_FFFF);
        do_write(3'd3, 32'h0000_0FF0);
        do_write(3'd5, 32'h00FE_F0FB);

        // R4 clear only the bits written as one
        @(negedge clk); msi_evt = 1; pme_evt = 1;
        @(negedge clk); msi_evt = 0; pme_evt = 0;
        do_write(3'd0, 32'h0000_0080);
        rd_check("R4 partial clear", 3'd0, 32'h0100_0000);
        clear_all();

        // R5 set beats simultaneous clear
        @(negedge clk);
        pme_evt = 1; wr_en = 1; addr = 3'd0; wdata = 32'h0000_0080;
        @(negedge clk);
        pme_evt = 0; wr_en = 0; wdata = '0;
        rd_check("R5 set wins", 3'd0, 32'h0000_0080);
        clear_all();

        // R6/R7 unmask power-state change; summary re-arms while pending
        do_write(3'd3, 32'h0000_0FE0);
        @(negedge clk); pwr_chg_evt = 1;
        @(negedge clk); pwr_chg_evt = 0;
        check("R7 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R7 irq raised", {31'h0, irq}, 32'h1);
        do_write(3'd4, 32'h0001_0000);
        rd_check("R7 summary re-armed", 3'd4, 32'h0001_0000);

        // R8 host mask gates irq
        do_write(3'd5, 32'h00FF_F0FB);
        check("R8 irq masked", {31'h0, irq}, 32'h0);
        rd_check("R8 host stat kept", 3'd4, 32'h0001_0000);
        do_write(3'd5, 32'h00FE_F0FB);
        check("R8 irq unmasked", {31'h0, irq}, 32'h1);

        do_write(3'd2, 32'h0000_0010);
        do_write(3'd4, 32'h0001_0000);
        rd_check("R7 summary cleared", 3'd4, 32'h0);
        check("R7 irq low", {31'h0, irq}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule